// File: doc/BRIEF.md
# Dual-Sided Interprocessor Mailbox

This block connects two processors, called side A and side B, through a shared set of message and doorbell registers. Each side has its own simple register port: a select, a write strobe, a byte address and 32-bit write and read data. Reads are combinational, so the value is returned in the same cycle as the access. Each side has four transmit registers. A word written into transmit register n on one side appears in receive register n on the other side. A transmit-empty flag on the writer and a receive-full flag on the reader implement the handshake for each channel.

Each side also has a control register and a status register. The control register holds the interrupt enables and four doorbell request bits. Setting a doorbell request raises the matching doorbell-pending flag on the opposite side, where software clears it by writing one. Each side has one interrupt line. It is high while any of that side's status flags is set together with its enable.

Each side also has a synchronous soft reset input. The opposite side sees this soft reset as a status bit. A parameter selects between two address maps.

Top module: `ipc_mbox`

## Requirements
- R1: After reset, both control registers read 0. Both status registers read 0x00F0_0000: every transmit-empty flag is 1, every receive-full flag is 0 and every doorbell-pending flag is 0.
- R2: With ALT_MAP=0 the map is:
  - transmit n at 0x00+4n
  - receive n at 0x10+4n
  - status at 0x20
  - control at 0x24

  With ALT_MAP=1 the map is:
  - transmit n at 0x20+4n
  - receive n at 0x40+4n
  - status at 0x60
  - control at 0x64

  Other addresses read 0 and ignore writes. Reading a transmit register returns the last word written to it.
- R3: In both registers, channel n uses bit base+3-n. Status bases: doorbell pending at 28, receive full at 24, transmit empty at 20. Control bases: doorbell enable at 28, receive enable at 24, transmit enable at 20, doorbell request at 16. Control bits 15:0 always read 0.
- R4: A write to transmit register n stores the word. From the next cycle, the writer's transmit-empty n is 0, the peer's receive-full n is 1, and the peer's receive register n returns the word.
- R5: A read of receive register n while its receive-full flag is set clears that flag at the next edge. The writer's transmit-empty n is set one cycle later. A read while the flag is clear changes nothing.
- R6: A write to transmit register n wins over a read of receive register n in the same cycle. It also wins over a transmit-empty release pending for channel n. In both cases receive-full n becomes 1 and transmit-empty n stays 0.
- R7: Writing 1 to doorbell request n makes the bit read 1 in the next cycle. The following edge sets doorbell-pending n on the peer and clears the request bit.
- R8: Writing 1 to a doorbell-pending status bit clears it, and writing 0 leaves it unchanged. A set arriving from the peer in the same cycle as the clear wins.
- R9: A side's interrupt output is high in exactly the cycles in which any status flag of that side is 1 together with its enable bit in that side's control register.
- R10: While a side's soft reset is high, the peer's status bit 9 reads 1 and bus accesses from the resetting side have no effect. At the next edge every channel flag returns to its reset value. All doorbell-pending flags clear, and the resetting side's control register clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| a_srst | input | 1 | Side A synchronous soft reset |
| a_sel | input | 1 | Side A access select |
| a_wr | input | 1 | Side A write strobe (read when low) |
| a_addr | input | AW | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (same cycle) |
| a_irq | output | 1 | Side A interrupt |
| b_srst | input | 1 | Side B synchronous soft reset |
| b_sel | input | 1 | Side B access select |
| b_wr | input | 1 | Side B write strobe (read when low) |
| b_addr | input | AW | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (same cycle) |
| b_irq | output | 1 | Side B interrupt |

## Verification
Read data and the interrupt lines are combinational functions of registered state, so they are due in the same cycle. Transmit writes, receive-full clears, control writes and pending clears are due one edge after the access. A transmit-empty release is due two edges after the receive read, and a doorbell reaches the peer's pending flag two edges after the control write. The bench drives each access just after a falling edge and samples read data and both interrupt lines a quarter period later. Only then does its model move one edge forward, so reads made in the cycle straight after a receive read or a doorbell request confirm that the delayed flag has not yet moved. A second instance built with the alternate map gets the same accesses with translated addresses and must return the same data.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int NCH = 4;
    localparam int DW  = 32;

    localparam int GIP_LSB  = 28;
    localparam int RF_LSB   = 24;
    localparam int TE_LSB   = 20;
    localparam int GIR_LSB  = 16;
    localparam int PEER_RST = 9;

    localparam logic [DW-1:0] CTRL_MASK = 32'hFFFF_0000;

    typedef enum logic [2:0] {
        RD_NONE = 3'd0,
        RD_TX   = 3'd1,
        RD_RX   = 3'd2,
        RD_SR   = 3'd3,
        RD_CR   = 3'd4
    } rd_kind_e;

    typedef struct packed {
        logic [NCH-1:0]     tx_wr;
        logic [NCH-1:0]     rx_rd;
        logic               sr_wr;
        logic               cr_wr;
        rd_kind_e           kind;
        logic [1:0]         idx;
    } dec_t;

    // channel n sits at field bit NCH-1-n; the mapping is its own inverse
    function automatic logic [NCH-1:0] flip(input logic [NCH-1:0] v);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[NCH-1-i] = v[i];
        return r;
    endfunction

endpackage

// File: rtl/ipc_mbox_dec.sv
module ipc_mbox_dec
    import ipc_mbox_pkg::*;
#(
    parameter bit ALT_MAP = 1'b0,
    parameter int AW      = 8
) (
    input  logic          en,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output dec_t          dec
);

    localparam int TX_BASE = ALT_MAP ? 'h20 : 'h00;
    localparam int RX_BASE = ALT_MAP ? 'h40 : 'h10;
    localparam int SR_OFF  = ALT_MAP ? 'h60 : 'h20;
    localparam int CR_OFF  = SR_OFF + 4;

    always_comb begin
        dec      = '0;
        dec.kind = RD_NONE;
        if (sel) begin
            for (int n = 0; n < NCH; n++) begin
                if (addr == AW'(TX_BASE + 4*n)) begin
                    if (wr) dec.tx_wr[n] = en;
                    else begin
                        dec.kind = RD_TX;
                        dec.idx  = 2'(n);
                    end
                end
                if (addr == AW'(RX_BASE + 4*n)) begin
                    if (!wr) begin
                        dec.rx_rd[n] = en;
                        dec.kind     = RD_RX;
                        dec.idx      = 2'(n);
                    end
                end
            end
            if (addr == AW'(SR_OFF)) begin
                if (wr) dec.sr_wr = en;
                else    dec.kind  = RD_SR;
            end
            if (addr == AW'(CR_OFF)) begin
                if (wr) dec.cr_wr = en;
                else    dec.kind  = RD_CR;
            end
        end
    end

endmodule

// File: rtl/ipc_mbox_lane.sv
module ipc_mbox_lane
    import ipc_mbox_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [NCH-1:0]          tx_wr,
    input  logic [DW-1:0]           wdata,
    input  logic [NCH-1:0]          rx_rd,
    output logic [NCH-1:0][DW-1:0]  data,
    output logic [NCH-1:0]          te,
    output logic [NCH-1:0]          rf
);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] data;
        logic [NCH-1:0]         te;
        logic [NCH-1:0]         rf;
        logic [NCH-1:0]         rel;
    } lane_t;

    localparam lane_t LANE_RST = '{data: '0, te: '1, rf: '0, rel: '0};

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (flush) begin
            lane_d = LANE_RST;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                lane_d.rel[n] = rx_rd[n] & lane_q.rf[n] & ~tx_wr[n];
                if (tx_wr[n]) begin
                    lane_d.data[n] = wdata;
                    lane_d.te[n]   = 1'b0;
                    lane_d.rf[n]   = 1'b1;
                end else begin
                    if (lane_q.rel[n]) lane_d.te[n] = 1'b1;
                    if (rx_rd[n])      lane_d.rf[n] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= LANE_RST;
        else        lane_q <= lane_d;
    end

    assign data = lane_q.data;
    assign te   = lane_q.te;
    assign rf   = lane_q.rf;

endmodule

// File: rtl/ipc_mbox_ctl.sv
module ipc_mbox_ctl
    import ipc_mbox_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           own_srst,
    input  logic           flush,
    input  logic           cr_wr,
    input  logic           sr_wr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] peer_gir,
    input  logic [NCH-1:0] te,
    input  logic [NCH-1:0] rf,
    output logic [DW-1:0]  ctrl,
    output logic [NCH-1:0] gir,
    output logic [NCH-1:0] gip,
    output logic           irq
);

    typedef struct packed {
        logic [DW-1:0]  ctrl;
        logic [NCH-1:0] gip;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        logic [NCH-1:0] clr;
        ctl_d = ctl_q;
        clr   = sr_wr ? flip(wdata[GIP_LSB +: NCH]) : '0;

        if (own_srst)   ctl_d.ctrl = '0;
        else if (cr_wr) ctl_d.ctrl = wdata & CTRL_MASK;
        else            ctl_d.ctrl[GIR_LSB +: NCH] = '0;

        if (flush) ctl_d.gip = '0;
        else       ctl_d.gip = (ctl_q.gip & ~clr) | peer_gir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctrl = ctl_q.ctrl;
    assign gir  = flip(ctl_q.ctrl[GIR_LSB +: NCH]);
    assign gip  = ctl_q.gip;
    assign irq  = |(ctl_q.gip & flip(ctl_q.ctrl[GIP_LSB +: NCH]))
                | |(rf        & flip(ctl_q.ctrl[RF_LSB  +: NCH]))
                | |(te        & flip(ctl_q.ctrl[TE_LSB  +: NCH]));

endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
    import ipc_mbox_pkg::*;
#(
    parameter bit ALT_MAP = 1'b0,
    parameter int AW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_srst,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    output logic          a_irq,
    input  logic          b_srst,
    input  logic          b_sel,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata,
    output logic          b_irq
);

    localparam int NS = 2;

    logic [NS-1:0]                  srst_pk, sel_pk, wr_pk, irq_pk;
    logic [NS-1:0][AW-1:0]          addr_pk;
    logic [NS-1:0][DW-1:0]          wdata_pk, rdata_pk, ctrl_pk;
    logic [NS-1:0][NCH-1:0]         txwr_pk, rxrd_pk, te_pk, rf_pk, gir_pk, gip_pk;
    logic [NS-1:0][NCH-1:0][DW-1:0] data_pk;
    logic                           flush;

    assign srst_pk  = {b_srst, a_srst};
    assign sel_pk   = {b_sel, a_sel};
    assign wr_pk    = {b_wr, a_wr};
    assign addr_pk  = {b_addr, a_addr};
    assign wdata_pk = {b_wdata, a_wdata};
    assign flush    = |srst_pk;

    for (genvar s = 0; s < NS; s++) begin : g_side
        localparam int P = NS - 1 - s;
        dec_t          dec;
        logic [DW-1:0] sr_word;
        logic [DW-1:0] rd;

        ipc_mbox_dec #(.ALT_MAP(ALT_MAP), .AW(AW)) u_dec (
            .en   (~srst_pk[s]),
            .sel  (sel_pk[s]),
            .wr   (wr_pk[s]),
            .addr (addr_pk[s]),
            .dec  (dec)
        );

        assign txwr_pk[s] = dec.tx_wr;
        assign rxrd_pk[s] = dec.rx_rd;

        // lane s carries words written by side s to side P
        ipc_mbox_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .tx_wr (dec.tx_wr),
            .wdata (wdata_pk[s]),
            .rx_rd (rxrd_pk[P]),
            .data  (data_pk[s]),
            .te    (te_pk[s]),
            .rf    (rf_pk[P])
        );

        ipc_mbox_ctl u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .own_srst (srst_pk[s]),
            .flush    (flush),
            .cr_wr    (dec.cr_wr),
            .sr_wr    (dec.sr_wr),
            .wdata    (wdata_pk[s]),
            .peer_gir (gir_pk[P]),
            .te       (te_pk[s]),
            .rf       (rf_pk[s]),
            .ctrl     (ctrl_pk[s]),
            .gir      (gir_pk[s]),
            .gip      (gip_pk[s]),
            .irq      (irq_pk[s])
        );

        always_comb begin
            sr_word                      = '0;
            sr_word[GIP_LSB +: NCH]      = flip(gip_pk[s]);
            sr_word[RF_LSB  +: NCH]      = flip(rf_pk[s]);
            sr_word[TE_LSB  +: NCH]      = flip(te_pk[s]);
            sr_word[PEER_RST]            = srst_pk[P];
        end

        always_comb begin
            case (dec.kind)
                RD_TX:   rd = data_pk[s][dec.idx];
                RD_RX:   rd = data_pk[P][dec.idx];
                RD_SR:   rd = sr_word;
                RD_CR:   rd = ctrl_pk[s];
                default: rd = '0;
            endcase
        end

        assign rdata_pk[s] = rd;
    end

    assign a_rdata = rdata_pk[0];
    assign b_rdata = rdata_pk[1];
    assign a_irq   = irq_pk[0];
    assign b_irq   = irq_pk[1];

endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk
    import ipc_mbox_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             srst,
    input logic [1:0][NCH-1:0]    tx_wr,
    input logic [1:0][NCH-1:0]    rx_rd,
    input logic [1:0][NCH-1:0]    te,
    input logic [1:0][NCH-1:0]    rf,
    input logic [1:0][NCH-1:0]    gir,
    input logic [1:0][NCH-1:0]    gip,
    input logic [1:0][DW-1:0]     ctrl,
    input logic [1:0]             irq
);

    for (genvar s = 0; s < 2; s++) begin : g_s
        localparam int P = 1 - s;

        a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[s][31:20] == 12'd0) |-> !irq[s]);

        a_r10_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
            srst[s] |=> (ctrl[s] == '0));

        a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
            (|srst) |=> (te[s] == '1 && rf[s] == '0 && gip[s] == '0));

        for (genvar n = 0; n < NCH; n++) begin : g_n
            a_r4_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (!(|srst) && tx_wr[s][n]) |=> (rf[P][n] && !te[s][n]));

            a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (!(|srst) && rx_rd[P][n] && !tx_wr[s][n]) |=> !rf[P][n]);

            a_r6_empty_after_take: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(te[s][n]) |-> !rf[P][n]);

            a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                !(te[s][n] && rf[P][n]));

            a_r7_ring: assert property (@(posedge clk) disable iff (!rst_n)
                (!(|srst) && gir[P][n]) |=> gip[s][n]);
        end
    end

endmodule

bind ipc_mbox ipc_mbox_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .srst  (srst_pk),
    .tx_wr (txwr_pk),
    .rx_rd (rxrd_pk),
    .te    (te_pk),
    .rf    (rf_pk),
    .gir   (gir_pk),
    .gip   (gip_pk),
    .ctrl  (ctrl_pk),
    .irq   (irq_pk)
);

// File: tb/ipc_mbox_bench.sv
module ipc_mbox_bench;

    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic        bsel [2];
    logic        bwr  [2];
    logic [7:0]  badr [2];
    logic [31:0] bwd  [2];
    logic        bsrst[2];
    logic [31:0] rdat [2];
    logic [31:0] rdalt[2];
    logic        irq  [2];
    logic        irqalt[2];
    logic [7:0]  aadr [2];

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    function automatic logic [7:0] to_alt(input logic [7:0] a);
        if (a < 8'h10)                     return a + 8'h20;
        else if (a < 8'h20)                return a + 8'h30;
        else if (a == 8'h20 || a == 8'h24) return a + 8'h40;
        else                               return a;
    endfunction

    assign aadr[0] = to_alt(badr[0]);
    assign aadr[1] = to_alt(badr[1]);

    ipc_mbox #(.ALT_MAP(1'b0), .AW(8)) u_ipc_mbox (
        .clk(clk), .rst_n(rst_n),
        .a_srst(bsrst[0]), .a_sel(bsel[0]), .a_wr(bwr[0]), .a_addr(badr[0]),
        .a_wdata(bwd[0]), .a_rdata(rdat[0]), .a_irq(irq[0]),
        .b_srst(bsrst[1]), .b_sel(bsel[1]), .b_wr(bwr[1]), .b_addr(badr[1]),
        .b_wdata(bwd[1]), .b_rdata(rdat[1]), .b_irq(irq[1])
    );

    ipc_mbox #(.ALT_MAP(1'b1), .AW(8)) u_ipc_mbox_alt (
        .clk(clk), .rst_n(rst_n),
        .a_srst(bsrst[0]), .a_sel(bsel[0]), .a_wr(bwr[0]), .a_addr(aadr[0]),
        .a_wdata(bwd[0]), .a_rdata(rdalt[0]), .a_irq(irqalt[0]),
        .b_srst(bsrst[1]), .b_sel(bsel[1]), .b_wr(bwr[1]), .b_addr(aadr[1]),
        .b_wdata(bwd[1]), .b_rdata(rdalt[1]), .b_irq(irqalt[1])
    );

    // model: index [s] is the side; te/rel by writer, rf/gip by receiver
    logic [31:0] m_data[2][4];
    bit   [3:0]  m_te[2], m_rf[2], m_rel[2], m_gip[2];
    logic [31:0] m_ctrl[2];

    function automatic bit [3:0] rv(input bit [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    function automatic logic [31:0] exp_status(input int s);
        logic [31:0] w = '0;
        w[31:28] = rv(m_gip[s]);
        w[27:24] = rv(m_rf[s]);
        w[23:20] = rv(m_te[s]);
        w[9]     = bsrst[1-s];
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input int s, input logic [7:0] a);
        if (a < 8'h10 && a[1:0] == 2'b00)      return m_data[s][a[3:2]];
        else if (a < 8'h20 && a[1:0] == 2'b00) return m_data[1-s][a[3:2]];
        else if (a == 8'h20)                   return exp_status(s);
        else if (a == 8'h24)                   return m_ctrl[s];
        else                                   return 32'h0;
    endfunction

    function automatic bit exp_irq(input int s);
        return |(m_gip[s] & rv(m_ctrl[s][31:28])) |
               |(m_rf[s]  & rv(m_ctrl[s][27:24])) |
               |(m_te[s]  & rv(m_ctrl[s][23:20]));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) m_data[s][n] = '0;
            m_te[s] = 4'hF; m_rf[s] = '0; m_rel[s] = '0; m_gip[s] = '0; m_ctrl[s] = '0;
        end
    endtask

    task automatic model_step();
        bit [3:0] txw[2], rxr[2], gir[2], nte[2], nrf[2], nrel[2], ngip[2];
        bit crw[2], srw[2];
        bit any;
        logic [31:0] nctrl[2];
        logic [31:0] ndat[2][4];
        any = bsrst[0] | bsrst[1];
        for (int s = 0; s < 2; s++) begin
            bit en;
            en = bsel[s] && !bsrst[s];
            for (int n = 0; n < 4; n++) begin
                txw[s][n] = en && bwr[s]  && badr[s] == 8'(4*n);
                rxr[s][n] = en && !bwr[s] && badr[s] == 8'(16 + 4*n);
            end
            crw[s] = en && bwr[s] && badr[s] == 8'h24;
            srw[s] = en && bwr[s] && badr[s] == 8'h20;
            gir[s] = rv(m_ctrl[s][19:16]);
        end
        for (int s = 0; s < 2; s++) begin
            int p;
            p = 1 - s;
            for (int n = 0; n < 4; n++) begin
                if (any) begin
                    ndat[s][n] = '0; nte[s][n] = 1; nrf[p][n] = 0; nrel[s][n] = 0;
                end else if (txw[s][n]) begin
                    ndat[s][n] = bwd[s]; nte[s][n] = 0; nrf[p][n] = 1; nrel[s][n] = 0;
                end else begin
                    ndat[s][n] = m_data[s][n];
                    nte[s][n]  = m_te[s][n] | m_rel[s][n];
                    nrf[p][n]  = rxr[p][n] ? 1'b0 : m_rf[p][n];
                    nrel[s][n] = rxr[p][n] & m_rf[p][n];
                end
            end
        end
        for (int s = 0; s < 2; s++) begin
            if (any) ngip[s] = '0;
            else     ngip[s] = (m_gip[s] & ~(srw[s] ? rv(bwd[s][31:28]) : 4'h0)) | gir[1-s];
            if (bsrst[s])    nctrl[s] = '0;
            else if (crw[s]) nctrl[s] = bwd[s] & 32'hFFFF_0000;
            else             nctrl[s] = m_ctrl[s] & ~32'h000F_0000;
        end
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) m_data[s][n] = ndat[s][n];
            m_te[s] = nte[s]; m_rf[s] = nrf[s]; m_rel[s] = nrel[s];
            m_gip[s] = ngip[s]; m_ctrl[s] = nctrl[s];
        end
    endtask

    task automatic op(input int s, input bit wr, input logic [7:0] a, input logic [31:0] d);
        bsel[s] = 1'b1; bwr[s] = wr; badr[s] = a; bwd[s] = d;
    endtask

    // one clock: sample reads and interrupts, advance model, cross the edge
    task automatic tick(input string tag);
        #(CLK_NS/4);
        for (int s = 0; s < 2; s++) begin
            if (bsel[s] && !bwr[s]) begin
                check(tag, rdat[s], exp_read(s, badr[s]));
                check({tag, " R2 alt map"}, rdalt[s], exp_read(s, badr[s]));
            end
            check("R9 irq", {31'd0, irq[s]}, {31'd0, exp_irq(s)});
            check("R2 R9 alt irq", {31'd0, irqalt[s]}, {31'd0, exp_irq(s)});
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            bsel[s] = 1'b0; bwr[s] = 1'b0; badr[s] = '0; bwd[s] = '0;
        end
    endtask

    task automatic wr1(input int s, input logic [7:0] a, input logic [31:0] d, input string tag);
        op(s, 1'b1, a, d); tick(tag);
    endtask

    task automatic rd1(input int s, input logic [7:0] a, input string tag);
        op(s, 1'b0, a, '0); tick(tag);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        for (int s = 0; s < 2; s++) begin
            bsel[s] = 0; bwr[s] = 0; badr[s] = '0; bwd[s] = '0; bsrst[s] = 0;
        end
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd1(0, 8'h20, "R1 status A");
        rd1(1, 8'h20, "R1 status B");
        rd1(0, 8'h24, "R1 ctrl A");
        check("R1 status const", exp_status(0), 32'h00F0_0000);

        // R4 write path
        wr1(0, 8'h04, 32'hDEAD_BEEF, "R4");
        rd1(0, 8'h20, "R4 A te1 low");
        rd1(1, 8'h20, "R4 B rf1 high");
        rd1(1, 8'h14, "R4 B rx1 data");
        rd1(0, 8'h20, "R5 A te1 still low");
        rd1(0, 8'h20, "R5 A te1 back");
        rd1(1, 8'h20, "R5 B rf1 clear");
        rd1(1, 8'h14, "R5 empty read");
        rd1(0, 8'h20, "R5 no change after empty read");
        rd1(0, 8'h04, "R2 tx readback");

        // R6 write wins over read in the same cycle
        wr1(0, 8'h08, 32'h1111_2222, "R6");
        op(1, 1'b0, 8'h18, '0);
        op(0, 1'b1, 8'h08, 32'h3333_4444);
        tick("R6 same-cycle read");
        rd1(0, 8'h20, "R6 te2 low");
        rd1(1, 8'h18, "R6 new data");
        // R6 write wins over pending release
        wr1(1, 8'h0C, 32'hAAAA_0001, "R6");
        rd1(0, 8'h1C, "R6 read ch3");
        wr1(1, 8'h0C, 32'hAAAA_0002, "R6 write during release");
        rd1(1, 8'h20, "R6 te3 stays low");
        rd1(0, 8'h20, "R6 rf3 high");

        // R3 control mask and layout
        wr1(0, 8'h24, 32'hFFFF_FFFF, "R3");
        rd1(0, 8'h24, "R3 ctrl with requests");
        rd1(0, 8'h24, "R7 requests cleared");
        rd1(1, 8'h20, "R7 B all pending");
        wr1(0, 8'h24, 32'h0, "R3");

        // R7 single doorbell channel 2
        wr1(1, 8'h20, 32'hF000_0000, "R8 clear all");
        wr1(0, 8'h24, 32'h1 << 17, "R7");
        rd1(1, 8'h20, "R7 not yet pending");
        rd1(1, 8'h20, "R7 pending ch2");
        rd1(0, 8'h24, "R7 request gone");

        // R8 write-one-to-clear
        wr1(1, 8'h20, 32'h0, "R8 zero write");
        rd1(1, 8'h20, "R8 unchanged");
        wr1(1, 8'h20, 32'h1 << 29, "R8 clear ch2");
        rd1(1, 8'h20, "R8 cleared");
        wr1(0, 8'h24, 32'h1 << 19, "R8");
        wr1(1, 8'h20, 32'h1 << 31, "R8 clear during set");
        rd1(1, 8'h20, "R8 set wins");

        // R9 interrupt enables
        wr1(1, 8'h24, 32'h8000_0000, "R9 gip0 enable");
        wr1(1, 8'h24, 32'h00F0_0000, "R9 te enable");
        wr1(1, 8'h24, 32'h0, "R9 off");

        // R2 unmapped
        wr1(0, 8'h30, 32'h5555_5555, "R2");
        rd1(0, 8'h30, "R2 unmapped read");

        // R10 soft reset of side A
        wr1(1, 8'h24, 32'h0F00_0000, "R10");
        wr1(0, 8'h24, 32'h00F0_0000, "R10");
        bsrst[0] = 1'b1;
        op(1, 1'b0, 8'h20, '0);
        op(0, 1'b1, 8'h00, 32'h7777_7777);
        tick("R10 peer sees reset");
        bsrst[0] = 1'b0;
        rd1(0, 8'h24, "R10 ctrl A cleared");
        rd1(1, 8'h24, "R10 ctrl B kept");
        rd1(1, 8'h20, "R10 B flags reset");
        rd1(0, 8'h20, "R10 A flags reset");
        rd1(1, 8'h10, "R10 write ignored");

        // random traffic
        for (int i = 0; i < 1500; i++) begin
            for (int s = 0; s < 2; s++) begin
                int k;
                logic [7:0] ch;
                k  = $urandom % 9;
                ch = 8'(($urandom % 4) * 4);
                case (k)
                    0, 1: op(s, 1'b1, ch, $urandom);
                    2, 3: op(s, 1'b0, 8'h10 + ch, '0);
                    4:    op(s, 1'b0, 8'h20, '0);
                    5:    op(s, 1'b0, ($urandom % 2) ? 8'h24 : ch, '0);
                    6:    op(s, 1'b1, 8'h24, ($urandom & 32'hFFF0_0000) |
                                ((($urandom % 4) == 0) ? ($urandom & 32'h000F_0000) : 32'h0));
                    7:    op(s, 1'b1, 8'h20, $urandom);
                    default: ;
                endcase
                bsrst[s] = (($urandom % 100) == 0);
            end
            tick("R4 R5 R7 R8 random");
            bsrst[0] = 1'b0;
            bsrst[1] = 1'b0;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule